// File: doc/BRIEF.md
# Single-Wire Read Slot Master

This block is the host side of bit reads on a single open-drain data line that a pull-up holds high. For each bit it asks for, it pulls the line low for a short strobe and then lets go. The slave answers a 0 by keeping the line low for a while after the strobe. It answers a 1 by leaving the line alone. The master samples the synchronized line at a fixed point after the strobe and before the slave lets go. It then keeps the line released for the rest of the slot and for a recovery gap before the next bit.

A request gives a bit count from 1 to 8. The block reads that many slots back to back and places bit i of the run in bit i of the output byte, so the least significant bit comes first. It then pulses done for one cycle and returns to idle, with the line released. The host sets all timing. The line may rest high in idle for as long as needed, and a new request then works normally. The timing is set by parameters in system clock cycles: STROBE_CYC for the strobe, SAMPLE_CYC for the sample point counted from slot start, SLOT_CYC for the slot and REC_CYC for the recovery.

The controller has five states:

- IDLE waits for a start.
- STROBE drives the line low.
- WINDOW waits for the sample point and captures the bit there.
- TAIL runs out the slot.
- RECOVER holds the line released.

The transitions are:

- start: IDLE to STROBE.
- strobe_end: STROBE to WINDOW.
- capture: WINDOW to TAIL.
- slot_end: TAIL to RECOVER.
- next_bit: RECOVER to STROBE.
- finish: RECOVER to IDLE, which pulses done.

Top module: `rdslot_master`

## Requirements
- R1: After reset and whenever no read is in progress, drive_o is 0, so the line is released. After reset, done_o is 0 and data_o is 0.
- R2: Every slot begins with drive_o high for exactly STROBE_CYC consecutive cycles. With the defaults this is 4.
- R3: A bit reads 0 when the slave holds the line low from the end of the strobe to past the sample point. It reads 1 when the slave leaves the line released.
- R4: Bit i of the run (i = 0 first) lands in data_o[i]. Every bit of data_o at or above the requested count is 0 when done_o is high.
- R5: len_m1_i holds the count minus one, so 0 means 1 bit and 7 means 8 bits. Exactly that many strobes are issued. done_o is high in the cycle after the last recovery cycle, which is n*(SLOT_CYC+REC_CYC) cycles after the cycle in which start was accepted.
- R6: done_o is high for exactly one cycle per completed read.
- R7: Between one strobe and the next, drive_o stays low for SLOT_CYC-STROBE_CYC+REC_CYC cycles. With the defaults this is 24.
- R8: A start_i pulse while a read is in progress is ignored. The run's bit count, timing and data are unchanged.
- R9: After the line has sat idle for any length of time, a new start performs a normal read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read run; taken only in IDLE |
| len_m1_i | input | 3 | Number of bits to read, minus one |
| line_i | input | 1 | Level of the shared data line (asynchronous) |
| drive_o | output | 1 | High pulls the line low; low releases it |
| data_o | output | 8 | Assembled bits, LSB first |
| done_o | output | 1 | One-cycle pulse when the run completes |

## Verification
The bench reads mixed patterns of zeros and ones at the shortest and longest counts. This catches a design that fills the byte from the wrong end, or that leaves stale bits above the count. It measures every strobe and every released gap to the cycle, and it times done from the accepted start. An off-by-one timer or a missed final recovery therefore shows up as a wrong cycle count. A second start is pulsed in the middle of a run with a different count, and a long idle is held before another read. A design that restarts or latches the new count would produce a different byte or end at the wrong time. A design that drives the line while idle would be seen holding drive_o high during the pause.

// File: rtl/rdslot_pkg.sv
package rdslot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STROBE  = 3'd1,
        ST_WINDOW  = 3'd2,
        ST_TAIL    = 3'd3,
        ST_RECOVER = 3'd4
    } slot_state_t;
endpackage

// File: rtl/rdslot_sync.sv
module rdslot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rdslot_timer.sv
module rdslot_timer #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [WIDTH-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_o <= '0;
        else if (clear_i) count_o <= '0;
        else              count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/rdslot_shreg.sv
module rdslot_shreg #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cap_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o
);
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 data_o[g] <= 1'b0;
                else if (clear_i)                           data_o[g] <= 1'b0;
                else if (cap_i && (idx_i == IDX_W'(g)))     data_o[g] <= bit_i;
            end
        end
    endgenerate
endmodule

// File: rtl/rdslot_master.sv
module rdslot_master
    import rdslot_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4,
    parameter int SAMPLE_CYC = 12,
    parameter int SLOT_CYC   = 20,
    parameter int REC_CYC    = 8,
    localparam int LEN_W     = $clog2(DATA_W),
    localparam int MAXT      = (SLOT_CYC > REC_CYC) ? SLOT_CYC : REC_CYC,
    localparam int TW        = $clog2(MAXT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic              line_i,
    output logic              drive_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    slot_state_t state, nxt;
    logic [TW-1:0]    tcnt;
    logic             t_clear;
    logic             cap;
    logic             line_s;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   bit_idx;
    logic             last_bit;
    logic             accept;

    rdslot_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(line_i), .sync_o(line_s)
    );

    rdslot_timer #(.WIDTH(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(t_clear), .count_o(tcnt)
    );

    rdslot_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .cap_i(cap),
        .idx_i(bit_idx[LEN_W-1:0]), .bit_i(line_s), .data_o(data_o)
    );

    assign accept   = (state == ST_IDLE) && start_i;
    assign last_bit = (bit_idx == ({1'b0, len_q} + 1'b1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state and control strobes
    always_comb begin
        nxt     = state;
        t_clear = 1'b0;
        cap     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                t_clear = 1'b1;
                if (start_i) nxt = ST_STROBE;
            end
            ST_STROBE: begin
                if (tcnt == TW'(STROBE_CYC - 1)) nxt = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (tcnt == TW'(SAMPLE_CYC - 1)) begin
                    cap = 1'b1;
                    nxt = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (tcnt == TW'(SLOT_CYC - 1)) begin
                    t_clear = 1'b1;
                    nxt     = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (tcnt == TW'(REC_CYC - 1)) begin
                    t_clear = 1'b1;
                    nxt     = last_bit ? ST_IDLE : ST_STROBE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // run bookkeeping: count, bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            bit_idx <= '0;
        end else if (accept) begin
            len_q   <= len_m1_i;
            bit_idx <= '0;
        end else if (cap) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state == ST_RECOVER) && (tcnt == TW'(REC_CYC - 1)) && last_bit;
    end

    assign drive_o = (state == ST_STROBE);
endmodule

// File: rtl/rdslot_checker.sv
module rdslot_checker
    import rdslot_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4,
    localparam int LEN_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_o,
    input  logic              done_o,
    input  logic [DATA_W-1:0] data_o,
    input  slot_state_t       state,
    input  logic [LEN_W-1:0]  len_q
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (drive_o) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    // R2: each strobe lasts exactly STROBE_CYC cycles
    p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_o) |-> (hi_cnt == 16'(STROBE_CYC)));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: line released when the run completes
    p_done_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !drive_o);

    // R8: latched count cannot change during a run
    p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE) || $stable(len_q));

    // R4: no bits set at or above the requested count
    p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((data_o >> ({1'b0, len_q} + 1'b1)) == '0));
endmodule

bind rdslot_master rdslot_checker #(
    .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .drive_o(drive_o), .done_o(done_o),
    .data_o(data_o), .state(state), .len_q(len_q)
);

// File: tb/sim_rdslot_master.sv
`timescale 1ns/1ps
module sim_rdslot_master;
    localparam int STB = 4;
    localparam int SLT = 20;
    localparam int REC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] len_m1_i = 3'd0;
    logic       line_i;
    logic       drive_o;
    logic [7:0] data_o;
    logic       done_o;

    logic       slave_low = 1'b0;
    logic       armed = 1'b0;
    logic [7:0] slave_pat = 8'h00;
    int         slv_idx = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign line_i = !(drive_o || slave_low);

    rdslot_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_m1_i(len_m1_i),
        .line_i(line_i), .drive_o(drive_o), .data_o(data_o), .done_o(done_o)
    );

    // slave model: hold line low after strobe for a zero bit
    always begin
        @(negedge drive_o);
        if (armed && rst_n) begin
            if (slave_pat[slv_idx % 8] == 1'b0) begin
                slave_low = 1'b1;
                repeat (12) @(negedge clk);
                slave_low = 1'b0;
            end
            slv_idx = slv_idx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_o == 1'b0, "R1 drive after reset", int'(drive_o), 0);
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(data_o == 8'h00, "R1 data after reset", int'(data_o), 0);
    endtask

    // run a read; inj>0 pulses a second start at that cycle
    task automatic t_read(input logic [7:0] pat, input int n, input int inj, input string tag);
        int k = 0;
        int runs = 0;
        int hi = 0;
        int lo = 0;
        int bad_hi = 0;
        int bad_lo = 0;
        bit prev = 1'b0;
        bit first_ok;
        logic [7:0] mask;
        mask = (n == 8) ? 8'hFF : 8'((1 << n) - 1);
        slave_pat = pat;
        slv_idx = 0;
        armed = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        len_m1_i = 3'(n - 1);
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        first_ok = drive_o;
        while (!done_o && k < 400) begin
            if (drive_o) begin
                if (!prev) begin
                    runs++;
                    if (runs > 1 && lo != SLT - STB + REC) bad_lo = lo;
                    hi = 0;
                end
                hi++;
            end else begin
                if (prev) begin
                    if (hi != STB) bad_hi = hi;
                    lo = 0;
                end
                lo++;
            end
            prev = drive_o;
            if (inj > 0 && k == inj) begin
                start_i = 1'b1;
                len_m1_i = 3'd7;
            end
            if (inj > 0 && k == inj + 1) start_i = 1'b0;
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        check(first_ok, {tag, " R2 strobe starts"}, int'(first_ok), 1);
        check(bad_hi == 0, {tag, " R2 strobe width"}, bad_hi, STB);
        check(bad_lo == 0, {tag, " R7 released gap"}, bad_lo, SLT - STB + REC);
        check(runs == n, {tag, " R5 strobe count"}, runs, n);
        check(k == n * (SLT + REC) + 1, {tag, " R5 done cycle"}, k, n * (SLT + REC) + 1);
        check(data_o == (pat & mask), {tag, " R3 R4 data"}, int'(data_o), int'(pat & mask));
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R6 done width"}, int'(done_o), 0);
        check(drive_o == 1'b0, {tag, " R1 idle release"}, int'(drive_o), 0);
        armed = 1'b0;
    endtask

    task automatic t_idle_pause();
        int drove = 0;
        repeat (500) begin
            @(negedge clk);
            if (drive_o) drove++;
        end
        check(drove == 0, "R9 R1 idle pause drive", drove, 0);
        t_read(8'h96, 8, 0, "R9 after idle");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_read(8'hA5, 8, 0, "full A5");
                t_read(8'h00, 8, 0, "all zero");
                t_read(8'hFF, 8, 0, "all one");
                t_read(8'hFF, 1, 0, "single one");
                t_read(8'hFE, 1, 0, "single zero");
                t_read(8'h3B, 5, 0, "five bits");
                t_read(8'h6D, 3, 40, "R8 busy start");
                t_idle_pause();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule